// File: doc/BRIEF.md
# Dual-Bank Page Map Translation Unit

This block turns the logical addresses of a processor into physical addresses for a 16 MB physical space. Pages are 8 KB. The map has 2048 entries split into two banks of 1024. One bank serves the running task. The other bank can be wiped in the background and then loaded for the next task. Switching tasks then costs a bank select rather than a full table reload. Software loads entries one at a time as the task touches new pages.

A separate table of write-protect bits covers the whole physical space at 2 KB granularity. These bits act only on writes made in unprivileged mode. All table updates go through one configuration port, and that port accepts a write only when the privileged flag is set. Each translation returns one cycle after its request. The result is either a physical address or exactly one of two faults: a map fault or a protect fault.

Top module: `pmu_xlate`

## Requirements
- R1: A request with `req_valid` high is answered in the next cycle with `rsp_valid` high. If the active bank's entry at index `req_addr[22:13]` is valid, `rsp_paddr` equals `{block, req_addr[12:0]}` and both faults are low.
- R2: If the selected entry is invalid, `rsp_map_fault` is high, `rsp_prot_fault` is low and `rsp_paddr` is zero.
- R3: The protect bit for a physical address sits in granule `paddr[23:11]`. Protect word `w` holds granule `16*w+b` in its bit `b`. An unprivileged write to a valid page whose granule bit is set raises `rsp_prot_fault`, with `rsp_paddr` zero. Other granules of the same page are unaffected.
- R4: Protect bits have no effect on reads or on privileged writes.
- R5: A configuration write with `cfg_priv` low changes nothing. With `cfg_priv` high, `cfg_tgt`=0 writes map entry `cfg_addr` of bank `cfg_bank`, where `cfg_data[10:0]` is the block and `cfg_data[11]` is the valid bit. `cfg_tgt`=1 writes `cfg_data[15:0]` to protect word `cfg_addr[8:0]`.
- R6: After reset, bank 0 is active, `clr_busy` is low, every map entry is invalid and no granule is protected.
- R7: A `clr_req` accepted while idle clears the bank that is inactive at that moment. `clr_busy` is high for exactly 1024 cycles, starting in the cycle after the request. After that, every entry of that bank is invalid.
- R8: While a clear runs, translations from the active bank give the same results as when idle.
- R9: `sel_req` makes `sel_bank` active for requests from the next cycle. If `sel_bank` is the bank being cleared, the change is held and takes effect in the cycle in which `clr_busy` falls.
- R10: A `clr_req` is ignored while `clr_busy` is high or when `sel_req` is high in the same cycle. Map writes aimed at the bank being cleared are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_tgt | input | 1 | 0 = map entry, 1 = protect word |
| cfg_bank | input | 1 | Map bank written |
| cfg_addr | input | 10 | Entry index or protect word index |
| cfg_data | input | 16 | Entry (valid, block) or protect bits |
| sel_req | input | 1 | Bank select strobe |
| sel_bank | input | 1 | Bank to make active |
| clr_req | input | 1 | Start clearing the inactive bank |
| req_valid | input | 1 | Translation request |
| req_addr | input | 23 | Logical address |
| req_write | input | 1 | Request is a write |
| req_priv | input | 1 | Request is privileged |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 24 | Physical address, zero on fault |
| rsp_map_fault | output | 1 | Entry invalid |
| rsp_prot_fault | output | 1 | Unprivileged write to protected granule |
| clr_busy | output | 1 | Background clear in progress |
| act_bank | output | 1 | Bank currently translating |

## Verification
Some properties are checked on every cycle. At most one fault is raised per response, and a fault only comes with a response. A protect fault always traces back to an unprivileged write. The page offset passes through unchanged on success. The bank being cleared is never the translating bank. No map write lands in the same cycle as a clear step. A clear always ends on the last index.

Other behaviour can only be shown by the bench's scenarios, which compare the block against a behavioural model every cycle. These include the exact addresses produced, ignored unprivileged updates, the 1024-cycle busy window, the deferred bank switch landing on the edge where busy falls, and the entries that are invalid after a clear.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   typedef enum logic {
      TGT_MAP  = 1'b0,
      TGT_PROT = 1'b1
   } cfg_tgt_e;

   localparam int unsigned N_BANKS = 2;
endpackage

// File: rtl/pmu_map_bank.sv
module pmu_map_bank #(
   parameter int IDX_W = 10,
   parameter int BLK_W = 11,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [BLK_W-1:0] wr_blk,
   input  logic             wr_vld,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [BLK_W-1:0] rd_blk,
   output logic             rd_vld
);
   logic [BLK_W-1:0] blk_mem [DEPTH];
   logic [DEPTH-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (wr_en) blk_mem[wr_idx] <= wr_blk;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (clr_en) vld_q[clr_idx] <= 1'b0;
         if (wr_en)  vld_q[wr_idx]  <= wr_vld;
      end
   end

   assign rd_blk = blk_mem[rd_idx];
   assign rd_vld = vld_q[rd_idx];

   // R10
   wr_vs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && clr_en));
endmodule

// File: rtl/pmu_prot_table.sv
module pmu_prot_table #(
   parameter int GIDX_W  = 13,
   parameter int PWORD_W = 16,
   localparam int SEL_W  = $clog2(PWORD_W),
   localparam int WA_W   = GIDX_W - SEL_W,
   localparam int NWORDS = 1 << WA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WA_W-1:0]    wr_addr,
   input  logic [PWORD_W-1:0] wr_data,
   input  logic [GIDX_W-1:0]  rd_gidx,
   output logic               rd_prot
);
   logic [PWORD_W-1:0] words [NWORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NWORDS; i++) words[i] <= '0;
      end else if (wr_en) begin
         words[wr_addr] <= wr_data;
      end
   end

   assign rd_prot = words[rd_gidx[GIDX_W-1:SEL_W]][rd_gidx[SEL_W-1:0]];
endmodule

// File: rtl/pmu_clr_seq.sv
module pmu_clr_seq #(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   assign last = busy && (idx == {IDX_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (busy) begin
         idx <= idx + 1'b1;
         if (last) busy <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end
   end

   // R7
   clr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(idx) == {IDX_W{1'b1}});
   // R7
   clr_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> idx == '0);
endmodule

// File: rtl/pmu_xlate.sv
module pmu_xlate #(
   parameter int LA_W    = 23,
   parameter int PA_W    = 24,
   parameter int PAGE_W  = 13,
   parameter int GRAN_W  = 11,
   parameter int PWORD_W = 16,
   localparam int IDX_W  = LA_W - PAGE_W,
   localparam int BLK_W  = PA_W - PAGE_W,
   localparam int GIDX_W = PA_W - GRAN_W,
   localparam int PWA_W  = GIDX_W - $clog2(PWORD_W),
   localparam int CFG_AW = (IDX_W > PWA_W) ? IDX_W : PWA_W,
   localparam int CFG_DW = (BLK_W + 1 > PWORD_W) ? BLK_W + 1 : PWORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_priv,
   input  logic              cfg_tgt,
   input  logic              cfg_bank,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_data,
   input  logic              sel_req,
   input  logic              sel_bank,
   input  logic              clr_req,
   input  logic              req_valid,
   input  logic [LA_W-1:0]   req_addr,
   input  logic              req_write,
   input  logic              req_priv,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_map_fault,
   output logic              rsp_prot_fault,
   output logic              clr_busy,
   output logic              act_bank
);
   import pmu_pkg::*;

   if (LA_W <= PAGE_W) begin : g_bad_la
      $error("logical width must exceed page offset width");
   end
   if (PA_W <= GRAN_W || GRAN_W > PAGE_W) begin : g_bad_gran
      $error("granule must fit inside a page and the physical space");
   end
   if ((1 << $clog2(PWORD_W)) != PWORD_W || PWA_W < 1) begin : g_bad_pword
      $error("protect word width must be a power of two below the granule count");
   end

   logic [IDX_W-1:0] rd_idx, seq_idx;
   logic [BLK_W-1:0] rd_blk_b [N_BANKS];
   logic             rd_vld_b [N_BANKS];
   logic             seq_busy, seq_last, seq_start, clearing;
   logic             clr_bank_q, pend_q, pend_bank_q;
   logic             map_wr, prot_wr, hit, prot_hit, pfault;
   logic [PA_W-1:0]  paddr_c;

   assign map_wr    = cfg_we && cfg_priv && (cfg_tgt == TGT_MAP);
   assign prot_wr   = cfg_we && cfg_priv && (cfg_tgt == TGT_PROT);
   assign rd_idx    = req_addr[LA_W-1:PAGE_W];
   assign seq_start = clr_req && !seq_busy && !sel_req;
   assign clearing  = seq_busy && !seq_last;

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic own_clr;
      assign own_clr = seq_busy && (clr_bank_q == 1'(b));
      pmu_map_bank #(.IDX_W(IDX_W), .BLK_W(BLK_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (map_wr && (cfg_bank == 1'(b)) && !own_clr),
         .wr_idx (cfg_addr[IDX_W-1:0]),
         .wr_blk (cfg_data[BLK_W-1:0]),
         .wr_vld (cfg_data[BLK_W]),
         .clr_en (own_clr),
         .clr_idx(seq_idx),
         .rd_idx (rd_idx),
         .rd_blk (rd_blk_b[b]),
         .rd_vld (rd_vld_b[b])
      );
   end

   pmu_clr_seq #(.IDX_W(IDX_W)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .start(seq_start),
      .busy (seq_busy),
      .idx  (seq_idx),
      .last (seq_last)
   );

   assign hit     = rd_vld_b[act_bank];
   assign paddr_c = {rd_blk_b[act_bank], req_addr[PAGE_W-1:0]};

   pmu_prot_table #(.GIDX_W(GIDX_W), .PWORD_W(PWORD_W)) u_prot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (prot_wr),
      .wr_addr(cfg_addr[PWA_W-1:0]),
      .wr_data(cfg_data[PWORD_W-1:0]),
      .rd_gidx(paddr_c[PA_W-1:GRAN_W]),
      .rd_prot(prot_hit)
   );

   assign pfault = hit && req_write && !req_priv && prot_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_bank    <= 1'b0;
         clr_bank_q  <= 1'b0;
         pend_q      <= 1'b0;
         pend_bank_q <= 1'b0;
      end else begin
         if (seq_start) clr_bank_q <= ~act_bank;
         if (seq_last && pend_q) begin
            act_bank <= pend_bank_q;
            pend_q   <= 1'b0;
         end
         if (sel_req) begin
            if (clearing && (sel_bank == clr_bank_q)) begin
               pend_q      <= 1'b1;
               pend_bank_q <= sel_bank;
            end else begin
               act_bank <= sel_bank;
               pend_q   <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_paddr      <= '0;
         rsp_map_fault  <= 1'b0;
         rsp_prot_fault <= 1'b0;
      end else begin
         rsp_valid      <= req_valid;
         rsp_map_fault  <= req_valid && !hit;
         rsp_prot_fault <= req_valid && pfault;
         rsp_paddr      <= (req_valid && hit && !pfault) ? paddr_c : '0;
      end
   end

   assign clr_busy = seq_busy;

   // R9
   bank_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |-> act_bank != clr_bank_q);
   // R2
   fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_map_fault, rsp_prot_fault}));
   // R2
   fault_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_map_fault || rsp_prot_fault) |-> rsp_valid);
   // R4
   prot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_prot_fault |-> $past(req_write && !req_priv));
   // R1
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_map_fault && !rsp_prot_fault)
         |-> rsp_paddr[PAGE_W-1:0] == $past(req_addr[PAGE_W-1:0]));
endmodule

// File: tb/tb_pmu_xlate.sv
module tb_pmu_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_priv = 0, cfg_tgt = 0, cfg_bank = 0;
   logic [9:0]  cfg_addr = '0;
   logic [15:0] cfg_data = '0;
   logic        sel_req = 0, sel_bank = 0, clr_req = 0;
   logic        req_valid = 0, req_write = 0, req_priv = 0;
   logic [22:0] req_addr = '0;
   logic        rsp_valid, rsp_map_fault, rsp_prot_fault, clr_busy, act_bank;
   logic [23:0] rsp_paddr;

   int n_chk = 0, n_fail = 0, cyc = 0, busy_run = 0;
   bit run_chk = 0;

   always #2.5 clk = ~clk;

   pmu_xlate dut (.*);

   // behavioural reference
   logic [10:0] m_blk [2][1024];
   bit          m_vld [2][1024];
   logic [15:0] m_prot [512];
   bit  m_act, m_busy, m_pend, m_pbank, m_cbank;
   int  m_cnt;
   bit  e_v, e_mf, e_pf;
   logic [23:0] e_pa;
   bit  p_busy, p_act, p_last, hitm, protm;
   int  ix, g;
   logic [23:0] pam;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < 1024; i++) m_vld[b][i] = 0;
         for (int w = 0; w < 512; w++) m_prot[w] = '0;
         m_act = 0; m_busy = 0; m_pend = 0; m_pbank = 0; m_cbank = 0; m_cnt = 0;
         e_v = 0; e_mf = 0; e_pf = 0; e_pa = '0;
      end else begin
         p_busy = m_busy; p_act = m_act; p_last = m_busy && (m_cnt == 1023);
         ix    = int'(req_addr[22:13]);
         hitm  = m_vld[p_act][ix];
         pam   = {m_blk[p_act][ix], req_addr[12:0]};
         g     = hitm ? int'(pam[23:11]) : 0;
         protm = m_prot[g / 16][g % 16];
         e_v   = req_valid;
         e_mf  = req_valid && !hitm;
         e_pf  = req_valid && hitm && req_write && !req_priv && protm;
         e_pa  = (req_valid && hitm && !e_pf) ? pam : 24'h0;
         if (cfg_we && cfg_priv) begin
            if (cfg_tgt == 1'b0) begin
               if (!(p_busy && m_cbank == cfg_bank)) begin
                  m_blk[cfg_bank][cfg_addr] = cfg_data[10:0];
                  m_vld[cfg_bank][cfg_addr] = cfg_data[11];
               end
            end else m_prot[cfg_addr[8:0]] = cfg_data;
         end
         if (p_busy) begin
            m_vld[m_cbank][m_cnt] = 0;
            if (p_last) begin
               m_busy = 0;
               if (m_pend) begin m_act = m_pbank; m_pend = 0; end
            end else m_cnt++;
         end
         if (sel_req) begin
            if (p_busy && !p_last && sel_bank == m_cbank) begin
               m_pend = 1; m_pbank = sel_bank;
            end else begin
               m_act = sel_bank; m_pend = 0;
            end
         end
         if (clr_req && !p_busy && !sel_req) begin
            m_busy = 1; m_cbank = !p_act; m_cnt = 0;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (run_chk) begin
         chk("R1 rsp_valid", 32'(rsp_valid), 32'(e_v));
         chk("R1 rsp_paddr", 32'(rsp_paddr), 32'(e_pa));
         chk("R2 map fault", 32'(rsp_map_fault), 32'(e_mf));
         chk("R3 prot fault", 32'(rsp_prot_fault), 32'(e_pf));
         chk("R7 busy", 32'(clr_busy), 32'(m_busy));
         chk("R9 active bank", 32'(act_bank), 32'(m_act));
         if (clr_busy) busy_run++;
         else if (busy_run != 0) begin
            chk("R7 busy length", 32'(busy_run), 32'd1024);
            busy_run = 0;
         end
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic cfg_wr(input bit tgt, input bit bank, input int addr,
                         input int data, input bit priv);
      cfg_we = 1; cfg_tgt = tgt; cfg_bank = bank; cfg_addr = 10'(addr);
      cfg_data = 16'(data); cfg_priv = priv;
      @(negedge clk);
      cfg_we = 0; cfg_priv = 0;
   endtask

   task automatic xl(input int addr, input bit wr, input bit priv, input int exp_pa,
                     input bit exp_mf, input bit exp_pf, input string tag);
      req_valid = 1; req_addr = 23'(addr); req_write = wr; req_priv = priv;
      @(negedge clk);
      req_valid = 0; req_write = 0; req_priv = 0;
      chk({tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
      chk({tag, " map fault"}, 32'(rsp_map_fault), 32'(exp_mf));
      chk({tag, " prot fault"}, 32'(rsp_prot_fault), 32'(exp_pf));
   endtask

   task automatic sel(input bit bank);
      sel_req = 1; sel_bank = bank;
      @(negedge clk);
      sel_req = 0;
   endtask

   task automatic clr();
      clr_req = 1;
      @(negedge clk);
      clr_req = 0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R6 reset state
      chk("R6 busy", 32'(clr_busy), 0);
      chk("R6 bank", 32'(act_bank), 0);
      chk("R6 rsp_valid", 32'(rsp_valid), 0);
      run_chk = 1;
      xl(23'h000123, 0, 1, 0, 1, 0, "R6 R2 invalid after reset");
      // R1 valid translations
      cfg_wr(0, 0, 0, 16'h0FFF, 1);
      cfg_wr(0, 0, 5, 16'h0812, 1);
      cfg_wr(0, 0, 1023, 16'h0803, 1);
      xl(23'h000ABC, 0, 0, 24'hFFEABC, 0, 0, "R1 idx0");
      xl(23'h00BF00, 1, 0, 24'h025F00, 0, 0, "R1 idx5");
      xl(23'h7FE001, 0, 0, 24'h006001, 0, 0, "R1 idx1023");
      // R5 unprivileged map write ignored
      cfg_wr(0, 0, 7, 16'h0801, 0);
      xl(23'h00E000, 0, 1, 0, 1, 0, "R5 unpriv map");
      // R3 protect granule 0x4B: word 4 bit 11
      cfg_wr(1, 0, 4, 16'h0800, 1);
      xl(23'h00BF00, 1, 0, 0, 0, 1, "R3 unpriv write protected");
      xl(23'h00A100, 1, 0, 24'h024100, 0, 0, "R3 other granule");
      xl(23'h00BF00, 1, 1, 24'h025F00, 0, 0, "R4 priv write");
      xl(23'h00BF00, 0, 0, 24'h025F00, 0, 0, "R4 unpriv read");
      cfg_wr(1, 0, 4, 0, 0);
      xl(23'h00BF00, 1, 0, 0, 0, 1, "R5 unpriv prot write");
      // R9 immediate select
      cfg_wr(0, 1, 5, 16'h0955, 1);
      xl(23'h00BF00, 0, 0, 24'h025F00, 0, 0, "R9 bank0 still");
      sel(1);
      xl(23'h00BF00, 0, 0, 24'h2ABF00, 0, 0, "R9 bank1");
      sel(0);
      // R7 R8 R10 background clear of bank1
      clr();
      chk("R7 busy raised", 32'(clr_busy), 1);
      xl(23'h000ABC, 0, 0, 24'hFFEABC, 0, 0, "R8 during clear");
      cfg_wr(0, 1, 9, 16'h0801, 1);
      clr();
      sel(1);
      chk("R9 deferred", 32'(act_bank), 0);
      while (clr_busy) @(negedge clk);
      chk("R9 after clear", 32'(act_bank), 1);
      xl(23'h00BF00, 0, 1, 0, 1, 0, "R7 cleared entry");
      xl(23'h012000, 0, 1, 0, 1, 0, "R10 write blocked");
      cfg_wr(0, 1, 9, 16'h0801, 1);
      xl(23'h012000, 0, 1, 24'h002000, 0, 0, "R10 write after clear");
      // R10 clear with select in same cycle ignored
      clr_req = 1; sel_req = 1; sel_bank = 1;
      @(negedge clk);
      clr_req = 0; sel_req = 0;
      chk("R10 clr with sel", 32'(clr_busy), 0);
      // second clear of bank0 while bank1 active
      clr();
      while (clr_busy) @(negedge clk);
      sel(0);
      xl(23'h000ABC, 0, 1, 0, 1, 0, "R7 bank0 cleared");
      repeat (3) @(negedge clk);
      summary();
   end
endmodule